// File: doc/BRIEF.md
# Half-Word Masked Control Register Bank

This block is the software-visible control slice of a timer-style peripheral with waveform and capture functions. It holds four control registers that are all written through a per-bit write mask. The upper 16 bits of each write data word select which of the lower 16 bits change, so two agents can update different fields of the same register without a read-modify-write race. It also holds an interrupt status register whose bits are cleared by writing ones.

The block also generates single-cycle command strobes for the datapath. It takes event pulses from the waveform and capture logic and drives one combined interrupt line. A separate end-of-run input lets the datapath drop the clock-enable and output-enable bits by itself when a one-shot sequence finishes.

The register port is a plain single-cycle interface with address, write data, write strobe, read strobe and combinational read data. Only aligned 32-bit words are accessed. Word offsets are parameters, with defaults 0x00 enable, 0x04 control, 0x08 interrupt status, 0x0C interrupt enable and 0x10 interrupt mask.

Top module: `hwmask_regbank`

## Requirements
- R1: For the enable, control, interrupt-enable and interrupt-mask registers, lower bit n changes on a write only when write data bit n+16 is 1, and bits 31:16 always read back as 0.
- R2: A read or write whose address has bits 1:0 not equal to 00 has no effect and reads 0. An unmapped aligned address reads 0. The read data is 0 whenever the read strobe is low.
- R3: Enable register layout: bit0 clock enable, bit1 output enable, bit3 force clock enable and bit5 counter read enable are read-write and drive the outputs of the same names.
- R4: Enable bit2 (update) and bit4 (global join) are trigger bits. A masked write of 1 raises `update_pulse_o` or `join_pulse_o` for exactly the one cycle after the write. An unmasked write raises nothing, and both bits always read 0.
- R5: Interrupt status bit n (0..9) is set by a pulse on `evt_i[n]` and cleared by a status write with data bit n = 1. The upper half of that write is ignored.
- R6: When an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` is 1 exactly when some status bit is 1 with its enable bit 1 and its mask bit 0.
- R8: A pulse on `oneshot_done_i` clears the clock-enable and output-enable bits and leaves the other bits unchanged. The clear takes priority over a same-cycle write that sets them.
- R9: Control register bits above CTRL_BITS-1, interrupt bits above 9 and enable bits above 5 read 0 and ignore writes. `ctrl_o` follows the stored control bits.
- R10: After reset every register reads 0, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data: mask in [31:16], value in [15:0] |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| evt_i | input | NUM_IRQ | Interrupt event pulses |
| oneshot_done_i | input | 1 | End of one-shot run; drops clock and output enable |
| clk_en_o | output | 1 | Clock enable |
| out_en_o | output | 1 | Output enable |
| force_clk_o | output | 1 | Force clock enable |
| cnt_rd_en_o | output | 1 | Counter read enable |
| update_pulse_o | output | 1 | Commit-settings strobe |
| join_pulse_o | output | 1 | Global join strobe |
| ctrl_o | output | CTRL_BITS | Control register contents |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: a 9-bit control field, ten interrupt sources and an 8-bit address. With those values the reserved bits above the control field and above bit 9 can be reached, along with misaligned and unmapped offsets. A vector table walks masked, unmasked and partly masked writes. Directed cases then cover the same-cycle collisions: an event against a software clear, and the end-of-run clear against a software set.

// File: rtl/hwmask_regbank.sv
module hwmask_regbank #(
  parameter int ADDR_W    = 8,
  parameter int NUM_IRQ   = 10,
  parameter int CTRL_BITS = 9,
  parameter logic [ADDR_W-1:0] OFF_EN    = 'h00,
  parameter logic [ADDR_W-1:0] OFF_CTRL  = 'h04,
  parameter logic [ADDR_W-1:0] OFF_STAT  = 'h08,
  parameter logic [ADDR_W-1:0] OFF_IEN   = 'h0C,
  parameter logic [ADDR_W-1:0] OFF_IMASK = 'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_IRQ-1:0]   evt_i,
  input  logic                 oneshot_done_i,
  output logic                 clk_en_o,
  output logic                 out_en_o,
  output logic                 force_clk_o,
  output logic                 cnt_rd_en_o,
  output logic                 update_pulse_o,
  output logic                 join_pulse_o,
  output logic [CTRL_BITS-1:0] ctrl_o,
  output logic                 irq_o
);

  localparam int HALF = 16;

  logic [15:0] wmask, wval;
  logic word_ok, wr_en, wr_ctrl, wr_stat, wr_ien, wr_imask;

  assign wmask    = bus_wdata[31:16];
  assign wval     = bus_wdata[15:0];
  assign word_ok  = (bus_addr[1:0] == 2'b00);
  assign wr_en    = bus_we && word_ok && (bus_addr == OFF_EN);
  assign wr_ctrl  = bus_we && word_ok && (bus_addr == OFF_CTRL);
  assign wr_stat  = bus_we && word_ok && (bus_addr == OFF_STAT);
  assign wr_ien   = bus_we && word_ok && (bus_addr == OFF_IEN);
  assign wr_imask = bus_we && word_ok && (bus_addr == OFF_IMASK);

  function automatic logic [15:0] merge16(input logic [15:0] cur,
                                          input logic [15:0] m,
                                          input logic [15:0] v);
    return (cur & ~m) | (v & m);
  endfunction

  logic clk_en_q, out_en_q, force_q, cntrd_q, upd_q, join_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q <= 1'b0;
      out_en_q <= 1'b0;
      force_q  <= 1'b0;
      cntrd_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wmask[0]) clk_en_q <= wval[0];
        if (wmask[1]) out_en_q <= wval[1];
        if (wmask[3]) force_q  <= wval[3];
        if (wmask[5]) cntrd_q  <= wval[5];
      end
      if (oneshot_done_i) begin
        clk_en_q <= 1'b0;
        out_en_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q  <= 1'b0;
      join_q <= 1'b0;
    end else begin
      upd_q  <= wr_en && wmask[2] && wval[2];
      join_q <= wr_en && wmask[4] && wval[4];
    end
  end

  logic [CTRL_BITS-1:0] ctrl_q;
  logic [NUM_IRQ-1:0]   ien_q, imask_q, stat_q;
  logic [15:0] ctrl_mrg, ien_mrg, imask_mrg;

  assign ctrl_mrg  = merge16(HALF'(ctrl_q),  wmask, wval);
  assign ien_mrg   = merge16(HALF'(ien_q),   wmask, wval);
  assign imask_mrg = merge16(HALF'(imask_q), wmask, wval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      imask_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_mrg[CTRL_BITS-1:0];
      if (wr_ien)   ien_q   <= ien_mrg[NUM_IRQ-1:0];
      if (wr_imask) imask_q <= imask_mrg[NUM_IRQ-1:0];
    end
  end

  logic [NUM_IRQ-1:0] clr_bits;
  assign clr_bits = wr_stat ? wval[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_bits) | evt_i;
  end

  assign irq_o = |(stat_q & ien_q & ~imask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_re && word_ok) begin
      if (bus_addr == OFF_EN)
        bus_rdata = {26'b0, cntrd_q, 1'b0, force_q, 1'b0, out_en_q, clk_en_q};
      else if (bus_addr == OFF_CTRL)
        bus_rdata = {16'b0, HALF'(ctrl_q)};
      else if (bus_addr == OFF_STAT)
        bus_rdata = {16'b0, HALF'(stat_q)};
      else if (bus_addr == OFF_IEN)
        bus_rdata = {16'b0, HALF'(ien_q)};
      else if (bus_addr == OFF_IMASK)
        bus_rdata = {16'b0, HALF'(imask_q)};
    end
  end

  assign clk_en_o       = clk_en_q;
  assign out_en_o       = out_en_q;
  assign force_clk_o    = force_q;
  assign cnt_rd_en_o    = cntrd_q;
  assign update_pulse_o = upd_q;
  assign join_pulse_o   = join_q;
  assign ctrl_o         = ctrl_q;

endmodule

// File: rtl/hwmask_regbank_chk.sv
module hwmask_regbank_chk #(
  parameter int ADDR_W  = 8,
  parameter int NUM_IRQ = 10,
  parameter logic [ADDR_W-1:0] OFF_EN   = 'h00,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h08
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_we,
  input logic               bus_re,
  input logic [31:0]        bus_rdata,
  input logic [NUM_IRQ-1:0] evt_i,
  input logic [NUM_IRQ-1:0] stat_q,
  input logic               oneshot_done_i,
  input logic               clk_en_o,
  input logic               out_en_o,
  input logic               update_pulse_o,
  input logic               irq_o
);

  AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0); // R1

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == 32'h0); // R2

  AST_TRIGGER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == OFF_EN && bus_wdata[2] && bus_wdata[18] |=> update_pulse_o); // R4

  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFF_EN && bus_wdata[18]) |=> !update_pulse_o); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == OFF_STAT && evt_i == '0
    |=> (stat_q & $past(bus_wdata[NUM_IRQ-1:0])) == '0); // R5

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i != '0 |=> (stat_q & $past(evt_i)) == $past(evt_i)); // R6

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q == '0 |-> !irq_o); // R7

  AST_DONE_DROPS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_done_i |=> !clk_en_o && !out_en_o); // R8

endmodule

bind hwmask_regbank hwmask_regbank_chk #(
  .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .OFF_EN(OFF_EN), .OFF_STAT(OFF_STAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .evt_i(evt_i),
  .stat_q(stat_q), .oneshot_done_i(oneshot_done_i), .clk_en_o(clk_en_o),
  .out_en_o(out_en_o), .update_pulse_o(update_pulse_o), .irq_o(irq_o)
);

// File: tb/tb_hwmask_regbank.sv
module tb_hwmask_regbank;
  localparam logic [7:0] A_EN = 8'h00, A_CTRL = 8'h04, A_STAT = 8'h08,
                         A_IEN = 8'h0C, A_IMASK = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0, done_i = 1'b0;
  logic [9:0] evt_i = '0;
  logic clk_en_o, out_en_o, force_clk_o, cnt_rd_en_o, update_pulse_o, join_pulse_o, irq_o;
  logic [8:0] ctrl_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hwmask_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .oneshot_done_i(done_i), .clk_en_o(clk_en_o), .out_en_o(out_en_o),
    .force_clk_o(force_clk_o), .cnt_rd_en_o(cnt_rd_en_o),
    .update_pulse_o(update_pulse_o), .join_pulse_o(join_pulse_o),
    .ctrl_o(ctrl_o), .irq_o(irq_o)
  );

  localparam int NV = 12;
  localparam logic [71:0] TBL [NV] = '{
    {A_EN,    32'h003F_003F, 32'h0000_002B},
    {A_EN,    32'h0001_0000, 32'h0000_002A},
    {A_EN,    32'h0000_FFFF, 32'h0000_002A},
    {A_EN,    32'hFFC0_FFC0, 32'h0000_002A},
    {A_CTRL,  32'hFFFF_FFFF, 32'h0000_01FF},
    {A_CTRL,  32'h00F0_0000, 32'h0000_010F},
    {A_CTRL,  32'h0003_0002, 32'h0000_010E},
    {A_IEN,   32'h03FF_0155, 32'h0000_0155},
    {A_IEN,   32'h0200_0200, 32'h0000_0355},
    {A_IMASK, 32'hFFFF_02AA, 32'h0000_02AA},
    {A_IMASK, 32'h0000_03FF, 32'h0000_02AA},
    {A_STAT,  32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [9:0] ev, input logic dn);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_i = ev; done_i = dn;
    @(negedge clk);
    bus_we = 1'b0; evt_i = '0; done_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R10 outputs", {24'b0, clk_en_o, out_en_o, force_clk_o, cnt_rd_en_o,
                        update_pulse_o, join_pulse_o, irq_o, |ctrl_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (TBL[i]) begin
      rd(TBL[i][71:64], r);
      chk("R10 reset read", r, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, TBL[i][71:64], TBL[i][63:32], '0, 1'b0);
      rd(TBL[i][71:64], r);
      chk("R1 R9 masked write", r, TBL[i][31:0]);
    end
    chk("R9 ctrl_o", {23'b0, ctrl_o}, 32'h10E);
    chk("R3 enable outputs", {28'b0, cnt_rd_en_o, force_clk_o, out_en_o, clk_en_o}, 32'hE);

    cyc(1'b1, 8'h01, 32'h0002_0000, '0, 1'b0);
    rd(A_EN, r);  chk("R2 misaligned write ignored", r, 32'h2A);
    rd(8'h01, r); chk("R2 misaligned read zero", r, 32'h0);
    rd(8'h40, r); chk("R2 unmapped read zero", r, 32'h0);
    chk("R2 idle read zero", bus_rdata, 32'h0);

    cyc(1'b1, A_EN, 32'h0014_0014, '0, 1'b0);
    chk("R4 pulses high", {30'b0, update_pulse_o, join_pulse_o}, 32'h3);
    rd(A_EN, r); chk("R4 trigger bits read zero", r, 32'h2A);
    cyc(1'b0, A_EN, 32'h0, '0, 1'b0);
    chk("R4 pulses single cycle", {30'b0, update_pulse_o, join_pulse_o}, 32'h0);
    cyc(1'b1, A_EN, 32'h0000_0014, '0, 1'b0);
    chk("R4 unmasked trigger no pulse", {30'b0, update_pulse_o, join_pulse_o}, 32'h0);

    cyc(1'b0, A_STAT, 32'h0, 10'h002, 1'b0);
    rd(A_STAT, r); chk("R5 event sets", r, 32'h2);
    chk("R7 disabled source no irq", {31'b0, irq_o}, 32'h0);
    cyc(1'b0, A_STAT, 32'h0, 10'h001, 1'b0);
    chk("R7 enabled source irq", {31'b0, irq_o}, 32'h1);
    cyc(1'b1, A_STAT, 32'h0000_0001, '0, 1'b0);
    rd(A_STAT, r); chk("R5 write one clears", r, 32'h2);
    chk("R7 irq drops", {31'b0, irq_o}, 32'h0);

    cyc(1'b1, A_STAT, 32'h0000_0010, 10'h010, 1'b0);
    rd(A_STAT, r); chk("R6 set wins", r, 32'h12);
    chk("R7 irq from bit4", {31'b0, irq_o}, 32'h1);
    cyc(1'b1, A_STAT, 32'h0000_0012, '0, 1'b0);
    rd(A_STAT, r); chk("R5 clear two bits", r, 32'h0);

    cyc(1'b0, A_STAT, 32'h0, 10'h200, 1'b0);
    chk("R7 masked source no irq", {31'b0, irq_o}, 32'h0);
    cyc(1'b1, A_IMASK, 32'h0200_0000, '0, 1'b0);
    chk("R7 unmasked irq", {31'b0, irq_o}, 32'h1);
    cyc(1'b1, A_IEN, 32'h0200_0000, '0, 1'b0);
    chk("R7 disabled irq", {31'b0, irq_o}, 32'h0);
    cyc(1'b1, A_STAT, 32'hFFFF_0200, '0, 1'b0);
    rd(A_STAT, r); chk("R5 upper half ignored on clear", r, 32'h0);

    cyc(1'b1, A_EN, 32'h0003_0003, '0, 1'b0);
    rd(A_EN, r); chk("R3 set enables", r, 32'h2B);
    cyc(1'b0, A_EN, 32'h0, '0, 1'b1);
    rd(A_EN, r); chk("R8 done clears enables", r, 32'h28);
    chk("R8 outputs", {28'b0, cnt_rd_en_o, force_clk_o, out_en_o, clk_en_o}, 32'hC);
    cyc(1'b1, A_EN, 32'h0003_0003, '0, 1'b1);
    rd(A_EN, r); chk("R8 done beats write", r, 32'h28);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule